// File: doc/BRIEF.md
# Cyclic Sense Wake-Up Controller

This block watches a switch input while the chip sits in a low-power state. Sensing the switch costs current, so the block powers the sense output only for a short burst in each period. It samples the wake input near the end of that burst and compares the sample with a reference level taken just after entry. A difference produces a wake event, and cycling then stops.

Which transistor is pulsed, high-side or low-side, depends on how the output was driven just before entry. That drive code is latched when the block enters low power. For the rest of each period, after the burst, the opposite transistor holds the line. Time is counted in microsecond ticks. Both the burst length and the period come from small select codes that are latched at entry. Outside low power, the two driver enables follow the normal drive code directly.

Top module: `cyc_sense_wake`

## Requirements
- R1: After synchronous reset the block is idle, `wake_evt` is 0, and with `norm_drv` = 00 both driver enables are 0.
- R2: While idle, the drive code `norm_drv` passes straight to the enables: 00 → both off, 01 → `ls_en`, 10 → `hs_en`, 11 → both off.
- R3: A pulse on `lp_enter` while idle latches `norm_drv`, `act_sel` and `per_sel`. During the next cycle the enables show the latched drive code, whatever `norm_drv` does afterwards. In that cycle `wake_in` is captured as the reference.
- R4: The active phase starts on the cycle after the reference cycle and lasts A ticks, with A = ACT_BASE_TICKS << `act_sel`. With the defaults this gives 00=200, 01=400, 10=800 and 11=1600 µs. During the active phase only the latched driver is on: `hs_en` for code 10, `ls_en` for code 01. The two enables are never on together.
- R5: After the active phase, the opposite driver is on until the period of P ticks ends, with P = PER_BASE_TICKS << `per_sel`. With the defaults this gives 3, 6, 12, 24, 48, 96, 192 and 384 ms. The next active phase then begins at once.
- R6: `wake_in` is sampled at the last tick of each active phase. If it differs from the reference, `wake_evt` is 1 for exactly one cycle, both enables go to 0, and cycling stops until exit.
- R7: Changes of `wake_in` at any tick other than the last tick of an active phase raise no wake event.
- R8: If `cyc_en` is 0 at entry, or the latched drive code is 00 or 11, the block does not cycle. The latched drive is held on the enables and `wake_evt` stays 0.
- R9: A pulse on `lp_exit` returns the block to idle on the next cycle, from any state, so the enables again follow `norm_drv`. When `lp_exit` and `lp_enter` arrive together, `lp_exit` wins.
- R10: Phase timing advances only on cycles where `us_tick` is 1. Without ticks, the enables stay unchanged during cycling.
- R11: A pulse on `lp_enter` while already in low power has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle microsecond time base |
| lp_enter | input | 1 | Low-power entry strobe |
| lp_exit | input | 1 | Low-power exit strobe |
| cyc_en | input | 1 | Cyclic sensing enable, sampled at entry |
| norm_drv | input | 2 | Normal-mode drive code of the sense output |
| act_sel | input | 2 | Active-time select |
| per_sel | input | 3 | Period select |
| wake_in | input | 1 | Sensed switch level |
| hs_en | output | 1 | High-side driver enable |
| ls_en | output | 1 | Low-side driver enable |
| wake_evt | output | 1 | One-cycle wake event |

## Verification
The bench counts tick edges after the reference cycle. With t ticks counted, the enables one cycle after any edge are set by t mod P: a value below A means the active phase, and any other value means the rest phase. The reference cycle itself is the cycle after the `lp_enter` edge. `wake_evt` and the quiet enables appear in the cycle just after the sampling tick edge. An `lp_exit` shows on the enables one cycle after its edge. Inputs are driven and outputs checked at the falling edge, and each check is made before the inputs for the next rising edge are changed, so every comparison uses the cycle the count above predicts.

// File: rtl/cyc_sense_pkg.sv
package cyc_sense_pkg;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'b00,
        DRV_LOW  = 2'b01,
        DRV_HIGH = 2'b10,
        DRV_RSVD = 2'b11
    } drv_code_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_REF    = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_REST   = 3'd3,
        PH_HOLD   = 3'd4,
        PH_WOKEN  = 3'd5
    } phase_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } drv_pair_t;

    typedef struct packed {
        drv_code_e  drv;
        logic [1:0] act_sel;
        logic [2:0] per_sel;
    } lp_cfg_t;

    function automatic drv_pair_t decode_drv(input drv_code_e code);
        drv_pair_t p;
        p.hs = (code == DRV_HIGH);
        p.ls = (code == DRV_LOW);
        return p;
    endfunction

    function automatic drv_pair_t swap_pair(input drv_pair_t p);
        drv_pair_t q;
        q.hs = p.ls;
        q.ls = p.hs;
        return q;
    endfunction

    function automatic logic can_cycle(input logic en, input drv_code_e code);
        return en && ((code == DRV_LOW) || (code == DRV_HIGH));
    endfunction

endpackage

// File: rtl/cs_len_decode.sv
module cs_len_decode #(
    parameter int ACT_BASE_TICKS = 200,
    parameter int PER_BASE_TICKS = 3000,
    parameter int CW             = 19
) (
    input  logic [1:0]    act_sel,
    input  logic [2:0]    per_sel,
    output logic [CW-1:0] act_last,
    output logic [CW-1:0] per_last
);
    always_comb begin
        act_last = (CW'(ACT_BASE_TICKS) << act_sel) - CW'(1);
        per_last = (CW'(PER_BASE_TICKS) << per_sel) - CW'(1);
    end
endmodule

// File: rtl/cs_tick_counter.sv
module cs_tick_counter #(
    parameter int CW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/cs_seq.sv
module cs_seq
    import cyc_sense_pkg::*;
#(
    parameter int CW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lp_enter,
    input  logic          lp_exit,
    input  logic          us_tick,
    input  logic          cyc_en,
    input  logic          wake_in,
    input  lp_cfg_t       cfg_in,
    input  logic [CW-1:0] act_last,
    input  logic [CW-1:0] per_last,
    input  logic [CW-1:0] cnt,
    output phase_e        phase,
    output lp_cfg_t       cfg_q,
    output logic          wake_evt,
    output logic          cnt_clr,
    output logic          cnt_inc
);
    phase_e phase_n;
    logic   ref_q;
    logic   ref_load;
    logic   cfg_load;
    logic   evt_n;

    always_comb begin
        phase_n  = phase;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        evt_n    = 1'b0;
        ref_load = 1'b0;
        cfg_load = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (lp_enter) begin
                    cfg_load = 1'b1;
                    phase_n  = can_cycle(cyc_en, cfg_in.drv) ? PH_REF : PH_HOLD;
                end
            end
            PH_REF: begin
                ref_load = 1'b1;
                cnt_clr  = 1'b1;
                phase_n  = PH_ACTIVE;
            end
            PH_ACTIVE: begin
                if (us_tick) begin
                    if (cnt == act_last) begin
                        if (wake_in != ref_q) begin
                            evt_n   = 1'b1;
                            phase_n = PH_WOKEN;
                        end else begin
                            cnt_inc = 1'b1;
                            phase_n = PH_REST;
                        end
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            PH_REST: begin
                if (us_tick) begin
                    if (cnt == per_last) begin
                        cnt_clr = 1'b1;
                        phase_n = PH_ACTIVE;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            default: begin
            end
        endcase
        if (lp_exit) begin
            phase_n  = PH_IDLE;
            evt_n    = 1'b0;
            cfg_load = 1'b0;
            cnt_clr  = 1'b1;
            cnt_inc  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cfg_q    <= '0;
            ref_q    <= 1'b0;
            wake_evt <= 1'b0;
        end else begin
            phase    <= phase_n;
            wake_evt <= evt_n;
            if (cfg_load) cfg_q <= cfg_in;
            if (ref_load) ref_q <= wake_in;
        end
    end
endmodule

// File: rtl/cyc_sense_wake.sv
module cyc_sense_wake
    import cyc_sense_pkg::*;
#(
    parameter int ACT_BASE_TICKS = 200,
    parameter int PER_BASE_TICKS = 3000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       us_tick,
    input  logic       lp_enter,
    input  logic       lp_exit,
    input  logic       cyc_en,
    input  logic [1:0] norm_drv,
    input  logic [1:0] act_sel,
    input  logic [2:0] per_sel,
    input  logic       wake_in,
    output logic       hs_en,
    output logic       ls_en,
    output logic       wake_evt
);
    localparam int PER_SEL_W = 3;
    localparam int MAX_PER   = PER_BASE_TICKS << ((1 << PER_SEL_W) - 1);
    localparam int CW        = $clog2(MAX_PER);

    lp_cfg_t       cfg_in;
    lp_cfg_t       cfg_q;
    phase_e        phase_q;
    logic [CW-1:0] act_last;
    logic [CW-1:0] per_last;
    logic [CW-1:0] cnt;
    logic          cnt_clr;
    logic          cnt_inc;
    drv_pair_t     pair;

    always_comb begin
        cfg_in.drv     = drv_code_e'(norm_drv);
        cfg_in.act_sel = act_sel;
        cfg_in.per_sel = per_sel;
    end

    cs_len_decode #(
        .ACT_BASE_TICKS(ACT_BASE_TICKS),
        .PER_BASE_TICKS(PER_BASE_TICKS),
        .CW(CW)
    ) u_len (
        .act_sel (cfg_q.act_sel),
        .per_sel (cfg_q.per_sel),
        .act_last(act_last),
        .per_last(per_last)
    );

    cs_tick_counter #(.CW(CW)) u_cnt (
        .clk(clk),
        .rst(rst),
        .clr(cnt_clr),
        .inc(cnt_inc),
        .cnt(cnt)
    );

    cs_seq #(.CW(CW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .lp_enter(lp_enter),
        .lp_exit (lp_exit),
        .us_tick (us_tick),
        .cyc_en  (cyc_en),
        .wake_in (wake_in),
        .cfg_in  (cfg_in),
        .act_last(act_last),
        .per_last(per_last),
        .cnt     (cnt),
        .phase   (phase_q),
        .cfg_q   (cfg_q),
        .wake_evt(wake_evt),
        .cnt_clr (cnt_clr),
        .cnt_inc (cnt_inc)
    );

    always_comb begin
        unique case (phase_q)
            PH_IDLE:   pair = decode_drv(cfg_in.drv);
            PH_REF,
            PH_HOLD,
            PH_ACTIVE: pair = decode_drv(cfg_q.drv);
            PH_REST:   pair = swap_pair(decode_drv(cfg_q.drv));
            default:   pair = '0;
        endcase
    end

    assign hs_en = pair.hs;
    assign ls_en = pair.ls;
endmodule

// File: rtl/cyc_sense_wake_chk.sv
module cyc_sense_wake_chk
    import cyc_sense_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       us_tick,
    input logic       lp_exit,
    input logic [1:0] norm_drv,
    input logic [2:0] phase,
    input logic       hs_en,
    input logic       ls_en,
    input logic       wake_evt
);
    assert_drv_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));

    assert_wake_single_R6: assert property (@(posedge clk) disable iff (rst)
        wake_evt |=> !wake_evt);

    assert_wake_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        wake_evt |-> (!hs_en && !ls_en));

    assert_exit_restore_R9: assert property (@(posedge clk) disable iff (rst)
        lp_exit |=> ((hs_en == (norm_drv == 2'b10)) && (ls_en == (norm_drv == 2'b01))));

    assert_tick_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (((phase == 3'(PH_ACTIVE)) || (phase == 3'(PH_REST))) && !us_tick && !lp_exit)
        |=> $stable({hs_en, ls_en}));
endmodule

bind cyc_sense_wake cyc_sense_wake_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .us_tick (us_tick),
    .lp_exit (lp_exit),
    .norm_drv(norm_drv),
    .phase   (phase_q),
    .hs_en   (hs_en),
    .ls_en   (ls_en),
    .wake_evt(wake_evt)
);

// File: tb/tb_cyc_sense_wake.sv
module tb_cyc_sense_wake;
    localparam int ACT_B = 2;
    localparam int PER_B = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b0;
    logic       lp_enter = 1'b0;
    logic       lp_exit = 1'b0;
    logic       cyc_en = 1'b0;
    logic [1:0] norm_drv = 2'b00;
    logic [1:0] act_sel = 2'b00;
    logic [2:0] per_sel = 3'b000;
    logic       wake_in = 1'b0;
    logic       hs_en;
    logic       ls_en;
    logic       wake_evt;

    int n_chk = 0;
    int n_bad = 0;

    cyc_sense_wake #(.ACT_BASE_TICKS(ACT_B), .PER_BASE_TICKS(PER_B)) dut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .lp_enter(lp_enter),
        .lp_exit(lp_exit), .cyc_en(cyc_en), .norm_drv(norm_drv),
        .act_sel(act_sel), .per_sel(per_sel), .wake_in(wake_in),
        .hs_en(hs_en), .ls_en(ls_en), .wake_evt(wake_evt)
    );

    always #5 clk = ~clk;

    function automatic int pair_of(input logic [1:0] code);
        if (code == 2'b10) return 2;
        if (code == 2'b01) return 1;
        return 0;
    endfunction

    function automatic int swapped(input int p);
        if (p == 2) return 1;
        if (p == 1) return 2;
        return 0;
    endfunction

    function automatic int outs();
        return int'({hs_en, ls_en});
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Exit from low power, then confirm idle pass-through (R9).
    task automatic do_exit(input logic [1:0] code);
        lp_exit  = 1'b1;
        norm_drv = code;
        @(negedge clk);
        lp_exit = 1'b0;
        check("R9", outs(), pair_of(code));
    endtask

    task automatic run_lp(input logic [1:0] pre, input int ac, input int pc,
                          input int stride, input int wake_at, input bit glitch,
                          input bit refv, input int max_cyc);
        int  a_len;
        int  p_len;
        int  t;
        int  samples;
        int  after;
        bit  woke;
        bit  evt_exp;
        bit  tk;
        bit  samp;
        int  expv;
        string tag;
        a_len   = ACT_B << ac;
        p_len   = PER_B << pc;
        t       = 0;
        samples = 0;
        after   = 0;
        woke    = 1'b0;
        evt_exp = 1'b0;
        norm_drv = pre;
        act_sel  = 2'(ac);
        per_sel  = 3'(pc);
        cyc_en   = 1'b1;
        wake_in  = refv;
        lp_enter = 1'b1;
        us_tick  = 1'b0;
        @(negedge clk);
        lp_enter = 1'b0;
        norm_drv = 2'b00;
        check("R3", outs(), pair_of(pre));
        check("R3", int'(wake_evt), 0);
        @(negedge clk);
        for (int cyc = 0; cyc < max_cyc; cyc++) begin
            if (woke) expv = 0;
            else if ((t % p_len) < a_len) expv = pair_of(pre);
            else expv = swapped(pair_of(pre));
            if (cyc == 8) tag = "R11";
            else if (stride > 1) tag = "R10";
            else if (woke) tag = "R6";
            else if ((t % p_len) < a_len) tag = "R4";
            else tag = "R5";
            check(tag, outs(), expv);
            check(glitch ? "R7" : "R6", int'(wake_evt), int'(evt_exp));
            if (woke) begin
                after++;
                if (after == 3) break;
            end
            tk   = ((cyc % stride) == (stride - 1));
            samp = tk && ((t % p_len) == (a_len - 1)) && !woke;
            if (samp && (samples == wake_at)) wake_in = !refv;
            else if (glitch && !samp) wake_in = !refv;
            else wake_in = refv;
            us_tick  = tk;
            lp_enter = (cyc == 7);
            norm_drv = (cyc == 7) ? 2'(~pre) : 2'b00;
            @(negedge clk);
            evt_exp = 1'b0;
            if (!woke && tk) begin
                if (samp) begin
                    if (samples == wake_at) begin
                        woke    = 1'b1;
                        evt_exp = 1'b1;
                    end
                    samples++;
                end
                t++;
            end
        end
        lp_enter = 1'b0;
        us_tick  = 1'b0;
        wake_in  = refv;
        do_exit(2'b01);
    endtask

    task automatic run_hold(input logic [1:0] pre, input bit en);
        norm_drv = pre;
        act_sel  = 2'b00;
        per_sel  = 3'b000;
        cyc_en   = en;
        wake_in  = 1'b0;
        lp_enter = 1'b1;
        @(negedge clk);
        lp_enter = 1'b0;
        norm_drv = 2'b00;
        for (int cyc = 0; cyc < 2 * PER_B; cyc++) begin
            check("R8", outs(), pair_of(pre));
            check("R8", int'(wake_evt), 0);
            us_tick = 1'b1;
            wake_in = ~wake_in;
            @(negedge clk);
        end
        us_tick = 1'b0;
        do_exit(2'b10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", outs(), 0);
        check("R1", int'(wake_evt), 0);

        for (int c = 0; c < 4; c++) begin
            norm_drv = 2'(c);
            @(negedge clk);
            check("R2", outs(), pair_of(2'(c)));
        end

        // Exit wins over a simultaneous entry.
        lp_enter = 1'b1;
        lp_exit  = 1'b1;
        norm_drv = 2'b01;
        @(negedge clk);
        lp_enter = 1'b0;
        lp_exit  = 1'b0;
        norm_drv = 2'b10;
        @(negedge clk);
        check("R9", outs(), 2);

        // Sweep of active and period codes with a wake at the third sample.
        for (int pre_i = 1; pre_i <= 2; pre_i++)
            for (int ac = 0; ac < 4; ac++)
                for (int pc = 0; pc < 3; pc++)
                    run_lp(2'(pre_i), ac, pc, 1, 2, 1'b0, 1'(ac ^ pc), 4000);

        // Longest codes, wake at the first sample.
        run_lp(2'b10, 3, 7, 1, 0, 1'b0, 1'b1, 100);

        // Sparse ticks.
        run_lp(2'b10, 1, 0, 3, 1, 1'b0, 1'b0, 4000);
        run_lp(2'b01, 0, 1, 2, 0, 1'b0, 1'b1, 4000);

        // Input glitches away from sample ticks never wake.
        for (int ac = 0; ac < 4; ac++)
            run_lp(2'b01, ac, 0, 1, -1, 1'b1, 1'(ac), 3 * PER_B);

        // No cycling cases.
        run_hold(2'b10, 1'b0);
        run_hold(2'b01, 1'b0);
        run_hold(2'b00, 1'b1);
        run_hold(2'b11, 1'b1);

        // Exit in the middle of an active phase.
        norm_drv = 2'b10;
        act_sel  = 2'b11;
        per_sel  = 3'b000;
        cyc_en   = 1'b1;
        lp_enter = 1'b1;
        @(negedge clk);
        lp_enter = 1'b0;
        us_tick  = 1'b1;
        repeat (4) @(negedge clk);
        check("R4", outs(), 2);
        us_tick = 1'b0;
        do_exit(2'b01);

        finish_run();
    end
endmodule